// File: doc/BRIEF.md
# Two-Threshold Cluster Readout Filter

This block sits in a self-triggered front-end chip whose channels form a small two-dimensional grid. Each time slot delivers one amplitude per channel. A sample at or above the high threshold is a particle hit and is always read out. A sample that only reaches the low threshold is read out only when it lies in a region of interest, so that the tail of a cluster is kept without letting noise through everywhere. A region of interest is the 3×3 neighbourhood of every high hit in the same slot, clipped at the grid border.

Clusters that cross a chip border are completed by exchanging edge requests with the four neighbouring chips. For each edge, the block raises a request line when a high hit lies on that edge. It accepts the matching request lines from the neighbours and, for each one, opens the whole adjacent edge row or column. The region decision is made one cycle after the slot is taken, so that the neighbours' requests for the same slot can be included. Validated hits leave as a serial stream in ascending channel order. Each hit carries its channel, its amplitude and a flag that tells whether it passed the high threshold. A new slot is taken only when the previous one has drained.

Top module: `cluster_roi_filter`

## Requirements
- R1: During and directly after reset, hit_valid and roi_out are 0 and slot_ready is 1.
- R2: A channel whose amplitude is greater than or equal to thr_hi is always reported, with hit_is_hi = 1.
- R3: A channel whose amplitude is below thr_lo (and below thr_hi) is never reported.
- R4: A channel with thr_lo <= amplitude < thr_hi is reported with hit_is_hi = 0 if and only if it lies in a region of interest. A region of interest is either within one row and one column of a high hit in the same slot, or inside an edge row or column whose roi_in bit is set. Channel c = row*4 + col; row 0 is the north edge and row 3 the south edge; col 0 is the west edge and col 3 the east edge.
- R5: roi_out is nonzero only in the cycle after a slot is accepted. In that cycle, bit 0 (north), bit 1 (east), bit 2 (south) and bit 3 (west) are each 1 exactly when that edge row or column holds a high hit.
- R6: roi_in is sampled only at the end of the cycle after a slot is accepted; its value in any other cycle has no effect.
- R7: Reported hits appear one per cycle in strictly ascending channel order. The first one is visible in the second cycle after acceptance, and the hit count equals the number of channels that qualify.
- R8: slot_ready is 0 from the cycle after acceptance until the cycle after the last hit. A slot presented while slot_ready is 0 is ignored.
- R9: Each reported hit carries its channel index on hit_ch and that channel's amplitude on hit_amp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| slot_valid | input | 1 | A time slot is presented |
| slot_ready | output | 1 | Block can take a slot this cycle |
| slot_amp | input | 160 | Amplitudes, channel c at bits c*10 +: 10 |
| thr_hi | input | 10 | High threshold, sampled with the slot |
| thr_lo | input | 10 | Low threshold, sampled with the slot |
| roi_in | input | 4 | Neighbour edge requests {W,S,E,N} |
| roi_out | output | 4 | Own edge requests {W,S,E,N} |
| hit_valid | output | 1 | A validated hit is on the outputs |
| hit_ch | output | 4 | Channel index of the hit |
| hit_amp | output | 10 | Amplitude of the hit |
| hit_is_hi | output | 1 | Hit passed the high threshold |

## Verification
The bench places a lone high hit on every one of the sixteen channels in turn, with low-level samples everywhere else. A wrong neighbourhood shows up as missing or extra low hits, most visibly at corners and edges, where a design that wraps or fails to clip would report channels from the far side. Each of the sixteen roi_in combinations is applied with no high hit present. Opposite values are driven in every other cycle, so a design that samples the requests in the wrong cycle reports the wrong edge rows. Samples exactly at each threshold, equal thresholds, and slots offered while the stream is draining are also applied. A block that compared with > instead of >=, or that accepted the offered slot, would add or drop hits.

// File: rtl/cr_pkg.sv
// Shared constants for the cluster readout filter.
// Assumes: edge request vectors are ordered north, east, south, west.
package cr_pkg;
    localparam int EDGE_N = 0;
    localparam int EDGE_E = 1;
    localparam int EDGE_S = 2;
    localparam int EDGE_W = 3;
    localparam int NEDGE  = 4;
endpackage

// File: rtl/cr_classify.sv
// Stage 1: compares each channel of an accepted slot with both thresholds
// and registers amplitudes plus high/low masks; derives the edge requests.
// Assumes: channel c = row*COLS + col, row 0 north, col 0 west.
module cr_classify #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int AW   = 10,
    localparam int NCH = ROWS * COLS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              accept,
    input  logic [NCH*AW-1:0] amp_flat,
    input  logic [AW-1:0]     thr_hi,
    input  logic [AW-1:0]     thr_lo,
    output logic              s1_vld,
    output logic [NCH*AW-1:0] s1_amp,
    output logic [NCH-1:0]    s1_hi,
    output logic [NCH-1:0]    s1_lo,
    output logic [cr_pkg::NEDGE-1:0] edge_req
);
    import cr_pkg::*;

    logic [NCH-1:0] hi_d, lo_d;

    // per-channel threshold comparators
    for (genvar c = 0; c < NCH; c++) begin : g_cmp
        assign hi_d[c] = amp_flat[c*AW +: AW] >= thr_hi;
        assign lo_d[c] = !hi_d[c] && (amp_flat[c*AW +: AW] >= thr_lo);
    end

    // register the classified slot; masks are zero when no slot was taken
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_vld <= 1'b0;
            s1_hi  <= '0;
            s1_lo  <= '0;
            s1_amp <= '0;
        end else begin
            s1_vld <= accept;
            s1_hi  <= accept ? hi_d : '0;
            s1_lo  <= accept ? lo_d : '0;
            if (accept) s1_amp <= amp_flat;
        end
    end

    // OR of high hits along each chip edge
    always_comb begin
        edge_req = '0;
        for (int c = 0; c < COLS; c++) begin
            edge_req[EDGE_N] = edge_req[EDGE_N] | s1_hi[c];
            edge_req[EDGE_S] = edge_req[EDGE_S] | s1_hi[(ROWS-1)*COLS + c];
        end
        for (int r = 0; r < ROWS; r++) begin
            edge_req[EDGE_W] = edge_req[EDGE_W] | s1_hi[r*COLS];
            edge_req[EDGE_E] = edge_req[EDGE_E] | s1_hi[r*COLS + COLS - 1];
        end
    end

    AST_EDGE_ONLY_WITH_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        (|edge_req) |-> s1_vld); // R5
    AST_CLASS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_hi & s1_lo) == '0); // R4
endmodule

// File: rtl/cr_roi_map.sv
// Builds the region of interest from the high hits (3x3 neighbourhood,
// clipped at the border) and the neighbour edge requests, then selects
// the channels to read out.
// Assumes: pure combinational; hi and lo masks are disjoint.
module cr_roi_map #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    localparam int NCH = ROWS * COLS
) (
    input  logic [NCH-1:0]            hi,
    input  logic [NCH-1:0]            lo,
    input  logic [cr_pkg::NEDGE-1:0]  edge_in,
    output logic [NCH-1:0]            keep
);
    import cr_pkg::*;

    logic [NCH-1:0] region;

    // dilate the high-hit mask and add the requested edge lines
    always_comb begin
        region = '0;
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < COLS; c++) begin
                for (int dr = -1; dr <= 1; dr++) begin
                    for (int dc = -1; dc <= 1; dc++) begin
                        if ((r + dr >= 0) && (r + dr < ROWS) &&
                            (c + dc >= 0) && (c + dc < COLS) &&
                            hi[(r + dr)*COLS + (c + dc)])
                            region[r*COLS + c] = 1'b1;
                    end
                end
                if ((r == 0        && edge_in[EDGE_N]) ||
                    (r == ROWS - 1 && edge_in[EDGE_S]) ||
                    (c == 0        && edge_in[EDGE_W]) ||
                    (c == COLS - 1 && edge_in[EDGE_E]))
                    region[r*COLS + c] = 1'b1;
            end
        end
    end

    // high hits always pass, low hits only inside the region
    assign keep = hi | (lo & region);
endmodule

// File: rtl/cr_hit_serializer.sv
// Holds the selected-channel mask of one slot and emits one hit per cycle,
// lowest channel first.
// Assumes: load only arrives when the mask has drained.
module cr_hit_serializer #(
    parameter int NCH = 16,
    parameter int AW  = 10,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [NCH-1:0]    load_mask,
    input  logic [NCH-1:0]    load_hi,
    input  logic [NCH*AW-1:0] load_amp,
    output logic              idle,
    output logic              out_vld,
    output logic [CHW-1:0]    out_ch,
    output logic [AW-1:0]     out_amp,
    output logic              out_hi
);
    logic [NCH-1:0]    mask_q, hi_q, grant;
    logic [NCH*AW-1:0] amp_q;

    // lowest pending channel
    assign grant = mask_q & (~mask_q + 1'b1);

    // priority encoder for the granted channel index
    always_comb begin
        out_ch = '0;
        for (int i = NCH - 1; i >= 0; i--) begin
            if (mask_q[i]) out_ch = CHW'(i);
        end
    end

    // load a new slot or retire the channel just shown
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
            hi_q   <= '0;
            amp_q  <= '0;
        end else if (load) begin
            mask_q <= load_mask;
            hi_q   <= load_hi;
            amp_q  <= load_amp;
        end else begin
            mask_q <= mask_q & ~grant;
        end
    end

    assign out_vld = |mask_q;
    assign idle    = ~out_vld;
    assign out_amp = amp_q[out_ch*AW +: AW];
    assign out_hi  = hi_q[out_ch];

    AST_LOAD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> (mask_q == '0)); // R8
    AST_HIT_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (out_vld && $past(out_vld)) |-> (out_ch > $past(out_ch))); // R7
endmodule

// File: rtl/cluster_roi_filter.sv
// Two-threshold cluster readout filter for a ROWS x COLS channel grid.
// Slot taken -> classify (1 cycle, edge requests out) -> region decision
// with neighbour requests -> serial hit stream in channel order.
// Assumes: neighbours present their requests for a slot in the same cycle
// as this block presents its own.
module cluster_roi_filter #(
    parameter int ROWS = 4,
    parameter int COLS = 4,
    parameter int AW   = 10,
    localparam int NCH = ROWS * COLS,
    localparam int CHW = $clog2(NCH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              slot_valid,
    output logic              slot_ready,
    input  logic [NCH*AW-1:0] slot_amp,
    input  logic [AW-1:0]     thr_hi,
    input  logic [AW-1:0]     thr_lo,
    input  logic [3:0]        roi_in,
    output logic [3:0]        roi_out,
    output logic              hit_valid,
    output logic [CHW-1:0]    hit_ch,
    output logic [AW-1:0]     hit_amp,
    output logic              hit_is_hi
);
    logic              accept, s1_vld, ser_idle;
    logic [NCH*AW-1:0] s1_amp;
    logic [NCH-1:0]    s1_hi, s1_lo, keep;

    assign slot_ready = ~s1_vld & ser_idle;
    assign accept     = slot_valid & slot_ready;

    cr_classify #(.ROWS(ROWS), .COLS(COLS), .AW(AW)) u_classify (
        .clk(clk), .rst_n(rst_n), .accept(accept), .amp_flat(slot_amp),
        .thr_hi(thr_hi), .thr_lo(thr_lo), .s1_vld(s1_vld), .s1_amp(s1_amp),
        .s1_hi(s1_hi), .s1_lo(s1_lo), .edge_req(roi_out)
    );

    cr_roi_map #(.ROWS(ROWS), .COLS(COLS)) u_roi (
        .hi(s1_hi), .lo(s1_lo), .edge_in(roi_in), .keep(keep)
    );

    cr_hit_serializer #(.NCH(NCH), .AW(AW)) u_ser (
        .clk(clk), .rst_n(rst_n), .load(s1_vld), .load_mask(keep),
        .load_hi(s1_hi), .load_amp(s1_amp), .idle(ser_idle),
        .out_vld(hit_valid), .out_ch(hit_ch), .out_amp(hit_amp),
        .out_hi(hit_is_hi)
    );

    AST_READY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !slot_ready); // R8
    AST_ROI_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (|roi_out) |-> $past(accept)); // R5
    AST_NO_HIT_IN_ROI_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(accept) |-> !hit_valid); // R7
endmodule

// File: tb/cluster_roi_filter_tb.sv
module cluster_roi_filter_tb;
    localparam int AW = 10;
    localparam int NCH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic slot_valid = 1'b0;
    logic slot_ready;
    logic [NCH*AW-1:0] slot_amp = '0;
    logic [AW-1:0] thr_hi = '0, thr_lo = '0;
    logic [3:0] roi_in = '0, roi_out;
    logic hit_valid, hit_is_hi;
    logic [3:0] hit_ch;
    logic [AW-1:0] hit_amp;

    int total = 0;
    int bad = 0;
    logic [31:0] seed = 32'h1234_5678;

    always #5 clk = ~clk;

    cluster_roi_filter u_dut (
        .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
        .slot_amp(slot_amp), .thr_hi(thr_hi), .thr_lo(thr_lo), .roi_in(roi_in),
        .roi_out(roi_out), .hit_valid(hit_valid), .hit_ch(hit_ch),
        .hit_amp(hit_amp), .hit_is_hi(hit_is_hi)
    );

    function automatic logic [31:0] nxt(input logic [31:0] s);
        logic [31:0] x = s;
        x = x ^ (x << 13);
        x = x ^ (x >> 17);
        x = x ^ (x << 5);
        return x;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // runs one slot and compares every output against the bench model
    task automatic run_slot(input logic [AW-1:0] a[NCH], input logic [AW-1:0] th,
                            input logic [AW-1:0] tl, input logic [3:0] rin);
        logic [NCH-1:0] hi, lo, keep;
        logic [3:0] eo;
        int n;
        for (int c = 0; c < NCH; c++) begin
            hi[c] = a[c] >= th;
            lo[c] = !hi[c] && a[c] >= tl;
        end
        keep = '0;
        eo = '0;
        for (int r = 0; r < 4; r++) begin
            for (int c = 0; c < 4; c++) begin
                bit reg_b = 0;
                for (int rr = r - 1; rr <= r + 1; rr++)
                    for (int cc = c - 1; cc <= c + 1; cc++)
                        if (rr >= 0 && rr < 4 && cc >= 0 && cc < 4 && hi[rr*4+cc]) reg_b = 1;
                if ((r == 0 && rin[0]) || (c == 3 && rin[1]) ||
                    (r == 3 && rin[2]) || (c == 0 && rin[3])) reg_b = 1;
                keep[r*4+c] = hi[r*4+c] | (lo[r*4+c] & reg_b);
                if (hi[r*4+c]) begin
                    if (r == 0) eo[0] = 1;
                    if (c == 3) eo[1] = 1;
                    if (r == 3) eo[2] = 1;
                    if (c == 0) eo[3] = 1;
                end
            end
        end
        while (!slot_ready) @(negedge clk);
        for (int c = 0; c < NCH; c++) slot_amp[c*AW +: AW] = a[c];
        thr_hi = th;
        thr_lo = tl;
        roi_in = ~rin;      // R6: wrong cycle, must be ignored
        slot_valid = 1'b1;
        @(negedge clk);
        chk(roi_out == eo, "R5 roi_out", roi_out, eo);
        chk(!hit_valid, "R7 no hit in region cycle", hit_valid, 0);
        chk(!slot_ready, "R8 busy after accept", slot_ready, 0);
        slot_valid = 1'b0;
        roi_in = rin;
        @(negedge clk);
        roi_in = ~rin;      // R6: wrong cycle, must be ignored
        n = 0;
        for (int c = 0; c < NCH; c++) begin
            if (keep[c]) begin
                chk(hit_valid == 1'b1, "R7 hit expected", hit_valid, 1);
                chk(hit_ch == 4'(c), "R4/R7 channel", hit_ch, c);
                chk(hit_amp == a[c], "R9 amplitude", hit_amp, a[c]);
                chk(hit_is_hi == hi[c], "R2/R4 flag", hit_is_hi, hi[c]);
                chk(!slot_ready, "R8 busy while draining", slot_ready, 0);
                slot_amp = '1;   // R8: slot offered while busy, must be ignored
                thr_hi = '0;
                thr_lo = '0;
                slot_valid = 1'b1;
                n++;
                @(negedge clk);
            end
        end
        slot_valid = 1'b0;
        chk(!hit_valid, "R3/R7 hit count", n + 1, n);
        chk(slot_ready, "R8 ready after drain", slot_ready, 1);
        chk(roi_out == 4'd0, "R5 roi_out idle", roi_out, 0);
        roi_in = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [AW-1:0] a[NCH];
        logic [AW-1:0] tl, th;
        repeat (3) @(negedge clk);
        chk(!hit_valid, "R1 hit_valid in reset", hit_valid, 0);
        chk(roi_out == 0, "R1 roi_out in reset", roi_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(slot_ready, "R1 ready after reset", slot_ready, 1);
        chk(!hit_valid, "R1 hit_valid after reset", hit_valid, 0);

        // R4/R5: lone high hit on every channel, low samples elsewhere
        for (int p = 0; p < NCH; p++) begin
            for (int c = 0; c < NCH; c++) a[c] = (c == p) ? 10'd900 : 10'd300 + 10'(c);
            run_slot(a, 10'd800, 10'd200, 4'd0);
        end
        // R4/R6: every neighbour request combination, no high hit
        for (int m = 0; m < 16; m++) begin
            for (int c = 0; c < NCH; c++) a[c] = 10'd250 + 10'(c);
            run_slot(a, 10'd800, 10'd200, 4'(m));
        end
        // R2/R3: samples exactly at and just below the thresholds
        for (int c = 0; c < NCH; c++) a[c] = (c % 4 == 0) ? 10'd500 : (c % 4 == 1) ? 10'd499 :
                                            (c % 4 == 2) ? 10'd200 : 10'd199;
        run_slot(a, 10'd500, 10'd200, 4'd0);
        // R2: equal thresholds leave no low class
        run_slot(a, 10'd200, 10'd200, 4'hF);
        // R3: nothing above either threshold
        for (int c = 0; c < NCH; c++) a[c] = 10'd10;
        run_slot(a, 10'd1000, 10'd900, 4'hF);
        // mixed patterns
        for (int k = 0; k < 60; k++) begin
            seed = nxt(seed);
            tl = 10'(seed % 600);
            seed = nxt(seed);
            th = tl + 10'(seed % 400);
            for (int c = 0; c < NCH; c++) begin
                seed = nxt(seed);
                a[c] = 10'(seed % 1024);
            end
            seed = nxt(seed);
            run_slot(a, th, tl, seed[3:0]);
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule